// File: doc/BRIEF.md
# Address-Masked GPIO Port

An eight-pin general-purpose I/O port that sits on a simple single-cycle memory-mapped register bus. Each pin is individually switchable between input and output through a direction byte, and the block drives the pad output-enable and output-value lines while sampling the pad inputs through a two-flop synchronizer.

The data register is not reached at one address but through a window of addresses. Word-address bits [9:2] act as a per-pin mask on every data access. A write changes only the selected pins, so software can flip one pin with a single store and no read-modify-write. A read returns zero in every unselected position, so a single load can test one pin.

Top module: `gpio_port`

## Requirements
- R1: After synchronous reset, pad_oe is 0x00, pad_out is 0x00 and bus_rdata is 0x00, so every pin starts as an input.
- R2: The direction byte lives at byte address 0x400. Bit n set to 1 makes pin n an output and 0 makes it an input. It is written and read back as a whole byte, and pad_oe always equals it.
- R3: A write to a data-window address (0x000 to 0x3FC, word aligned) updates output bit n only when address bit n+2 is 1 and pin n is an output. Every other output bit keeps its value.
- R4: A data write to a pin configured as input leaves that pin's output bit unchanged. After the pin is switched to output, pad_out shows the bit's earlier value until software writes the pin again.
- R5: A read from the data window returns 0 in every bit position n whose address bit n+2 is 0.
- R6: In a selected position, a data read returns the driven output bit for an output pin. For an input pin it returns pad_in passed through two synchronizer flops: a pad change made before clock edge k is first returned by a read captured at edge k+2.
- R7: An access at an address with bit 10 set other than 0x400, or with address bits [1:0] not zero, is unmapped. Writes to it change nothing, and reads of it return 0x00.
- R8: bus_rdata is registered. It takes a new value one cycle after a read (bus_valid=1, bus_write=0) and holds its value in every cycle without a read.
- R9: pad_out presents the output register for all eight pins, whatever their direction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 11 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pad_oe | output | 8 | Per-pin output enable |
| pad_out | output | 8 | Per-pin output value |
| pad_in | input | 8 | Raw pad input levels |

## Verification
The bench builds the block with its defaults of eight pins and two synchronizer stages. At that size, all 256 address masks can be swept for data writes under two direction patterns, and for data reads under a mixed direction pattern. Every expected byte comes from a mask-and-merge formula in the bench. It also steps a pad change through the synchronizer one read at a time to pin down the two-cycle latency, and probes unmapped and misaligned addresses.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int NPINS       = 8;
    localparam int ADDR_W      = 11;
    localparam int WORD_W      = ADDR_W - 2;
    localparam int SYNC_STAGES = 2;

    typedef logic [NPINS-1:0] pin_vec_t;

    typedef enum logic [1:0] {
        ACC_NONE     = 2'd0,
        ACC_DATA     = 2'd1,
        ACC_DIR      = 2'd2,
        ACC_UNMAPPED = 2'd3
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e kind;
        logic      is_write;
        pin_vec_t  mask;
        pin_vec_t  wdata;
    } bus_req_t;

    typedef struct packed {
        pin_vec_t dir;
        pin_vec_t out;
    } port_state_t;

    // Merge new bits into old ones wherever en is set.
    function automatic pin_vec_t merge_bits(pin_vec_t old_v, pin_vec_t new_v, pin_vec_t en);
        return (old_v & ~en) | (new_v & en);
    endfunction

    // Value a data read sees in each position before masking.
    function automatic pin_vec_t pin_view(pin_vec_t dir, pin_vec_t out, pin_vec_t sampled);
        return (out & dir) | (sampled & ~dir);
    endfunction

endpackage

// File: rtl/gpio_decode.sv
module gpio_decode
    import gpio_pkg::*;
#(
    parameter int N  = NPINS,
    parameter int AW = ADDR_W
) (
    input  logic          valid,
    input  logic          write,
    input  logic [AW-1:0] addr,
    input  logic [N-1:0]  wdata,
    output bus_req_t      req
);
    localparam int WW = AW - 2;
    localparam logic [WW-1:0] DIR_WORD = WW'(1) << N;

    logic [WW-1:0] word;
    logic          aligned;

    assign word    = addr[AW-1:2];
    assign aligned = (addr[1:0] == 2'b00);

    always_comb begin
        req.is_write = write;
        req.mask     = addr[N+1:2];
        req.wdata    = wdata;
        if (!valid) begin
            req.kind = ACC_NONE;
        end else if (!aligned) begin
            req.kind = ACC_UNMAPPED;
        end else if (word < DIR_WORD) begin
            req.kind = ACC_DATA;
        end else if (word == DIR_WORD) begin
            req.kind = ACC_DIR;
        end else begin
            req.kind = ACC_UNMAPPED;
        end
    end
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync
    import gpio_pkg::*;
#(
    parameter int N      = NPINS,
    parameter int STAGES = SYNC_STAGES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    for (genvar b = 0; b < N; b++) begin : g_pin
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) begin
                chain <= '0;
            end else if (STAGES == 1) begin
                chain[0] <= d[b];
            end else begin
                chain <= {chain[STAGES-2:0], d[b]};
            end
        end
        assign q[b] = chain[STAGES-1];
    end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  bus_req_t    req,
    output port_state_t st
);
    port_state_t st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else if (req.is_write) begin
            unique case (req.kind)
                ACC_DIR:  st_q.dir <= req.wdata;
                ACC_DATA: st_q.out <= merge_bits(st_q.out, req.wdata, req.mask & st_q.dir);
                default:  ;
            endcase
        end
    end

    assign st = st_q;
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int N      = NPINS,
    parameter int AW     = ADDR_W,
    parameter int STAGES = SYNC_STAGES
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_valid,
    input  logic          bus_write,
    input  logic [AW-1:0] bus_addr,
    input  logic [N-1:0]  bus_wdata,
    output logic [N-1:0]  bus_rdata,
    output logic [N-1:0]  pad_oe,
    output logic [N-1:0]  pad_out,
    input  logic [N-1:0]  pad_in
);
    bus_req_t    req;
    port_state_t st;
    pin_vec_t    sampled;
    pin_vec_t    rd_next;
    pin_vec_t    rdata_q;

    gpio_decode #(.N(N), .AW(AW)) u_dec (
        .valid (bus_valid),
        .write (bus_write),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .req   (req)
    );

    gpio_regs u_regs (
        .clk (clk),
        .rst (rst),
        .req (req),
        .st  (st)
    );

    gpio_sync #(.N(N), .STAGES(STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (sampled)
    );

    always_comb begin
        unique case (req.kind)
            ACC_DATA: rd_next = pin_view(st.dir, st.out, sampled) & req.mask;
            ACC_DIR:  rd_next = st.dir;
            default:  rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (req.kind != ACC_NONE && !req.is_write) begin
            rdata_q <= rd_next;
        end
    end

    assign bus_rdata = rdata_q;
    assign pad_oe    = st.dir;
    assign pad_out   = st.out;
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk (
    input logic        clk,
    input logic        rst,
    input logic        bus_valid,
    input logic        bus_write,
    input logic [10:0] bus_addr,
    input logic [7:0]  bus_wdata,
    input logic [7:0]  bus_rdata,
    input logic [7:0]  pad_oe,
    input logic [7:0]  pad_out,
    input logic [7:0]  pad_in
);
    logic data_wr, data_rd, dir_wr, any_rd, unmapped_rd;

    assign data_wr     = bus_valid && bus_write && !bus_addr[10] && bus_addr[1:0] == 2'b00;
    assign data_rd     = bus_valid && !bus_write && !bus_addr[10] && bus_addr[1:0] == 2'b00;
    assign dir_wr      = bus_valid && bus_write && bus_addr == 11'h400;
    assign any_rd      = bus_valid && !bus_write;
    assign unmapped_rd = any_rd && bus_addr != 11'h400 && (bus_addr[10] || bus_addr[1:0] != 2'b00);

    // R2: output enables move only after a direction write
    a_r2_oe_needs_dir_write: assert property (@(posedge clk) disable iff (rst)
        !dir_wr |=> $stable(pad_oe));

    // R3: unaddressed output bits hold
    a_r3_unaddressed_hold: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pad_out ^ $past(pad_out)) & ~($past(data_wr) ? $past(bus_addr[9:2]) : 8'h00)) == 8'h00);

    // R4: bits of input pins never change
    a_r4_input_pins_hold: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pad_out ^ $past(pad_out)) & ~$past(pad_oe)) == 8'h00);

    // R5: unselected read positions are zero
    a_r5_read_masked: assert property (@(posedge clk) disable iff (rst)
        data_rd |=> (bus_rdata & ~$past(bus_addr[9:2])) == 8'h00);

    // R7: unmapped reads return zero
    a_r7_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        unmapped_rd |=> bus_rdata == 8'h00);

    // R8: read data holds without a read
    a_r8_rdata_hold: assert property (@(posedge clk) disable iff (rst)
        !any_rd |=> $stable(bus_rdata));

    logic unused_ok;
    assign unused_ok = ^{bus_wdata, pad_in};
endmodule

bind gpio_port gpio_port_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_oe    (pad_oe),
    .pad_out   (pad_out),
    .pad_in    (pad_in)
);

// File: tb/gpio_port_test.sv
`timescale 1ns/1ps
module gpio_port_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [10:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [7:0]  pad_oe;
    logic [7:0]  pad_out;
    logic [7:0]  pad_in = '0;

    int checks = 0;
    int errors = 0;
    logic [7:0] m_dir = '0;
    logic [7:0] m_out = '0;

    always #2.5 clk = ~clk;

    gpio_port uut (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_oe(pad_oe), .pad_out(pad_out), .pad_in(pad_in)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [10:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [10:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        d = bus_rdata;
    endtask

    task automatic set_dir(input logic [7:0] d);
        bus_wr(11'h400, d);
        m_dir = d;
        chk("R2 pad_oe follows direction", pad_oe, m_dir);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] r;
        logic [7:0] v;
        logic [7:0] old_view;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk("R1 reset pad_oe", pad_oe, 8'h00);
        chk("R1 reset pad_out", pad_out, 8'h00);
        chk("R1 reset rdata", bus_rdata, 8'h00);
        bus_rd(11'h400, r);
        chk("R1 reset direction", r, 8'h00);

        // R4: write while all inputs, then switch to output
        bus_wr(11'h3FC, 8'hFF);
        chk("R4 write to input pins ignored", pad_out, 8'h00);
        set_dir(8'hFF);
        chk("R4 old value after switch to output", pad_out, 8'h00);
        bus_rd(11'h400, r);
        chk("R2 direction readback", r, 8'hFF);

        // R3 / R9: exhaustive mask sweep under two direction patterns
        for (int p = 0; p < 2; p++) begin
            set_dir(p == 0 ? 8'hA5 : 8'hFF);
            for (int m = 0; m < 256; m++) begin
                v = 8'((m * 37 + 11 + p * 90) & 8'hFF);
                bus_wr(11'(m << 2), v);
                m_out = (m_out & ~(8'(m) & m_dir)) | (v & 8'(m) & m_dir);
                chk("R3 R9 masked write", pad_out, m_out);
            end
        end

        // R5 / R6: read sweep with mixed directions
        set_dir(8'h3C);
        pad_in = 8'h96;
        repeat (3) @(negedge clk);
        for (int m = 0; m < 256; m++) begin
            bus_rd(11'(m << 2), r);
            chk("R5 R6 masked read", r, ((m_out & m_dir) | (8'h96 & ~m_dir)) & 8'(m));
        end

        // R6: synchronizer latency, back-to-back reads
        old_view = (m_out & m_dir) | (8'h96 & ~m_dir);
        @(negedge clk);
        pad_in = 8'h69; bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 11'h3FC;
        @(negedge clk);
        chk("R6 latency edge k", bus_rdata, old_view);
        @(negedge clk);
        chk("R6 latency edge k+1", bus_rdata, old_view);
        @(negedge clk);
        chk("R6 latency edge k+2", bus_rdata, (m_out & m_dir) | (8'h69 & ~m_dir));
        bus_valid = 1'b0;

        // R8: rdata holds across writes and idle cycles
        r = bus_rdata;
        bus_wr(11'h400, 8'h3C);
        repeat (4) @(negedge clk);
        chk("R8 rdata holds", bus_rdata, r);

        // R7: unmapped and misaligned addresses
        bus_wr(11'h404, 8'h00);
        bus_wr(11'h7FC, 8'h00);
        chk("R7 unmapped write leaves direction", pad_oe, m_dir);
        bus_wr(11'h3FD, 8'h00);
        chk("R7 misaligned write leaves outputs", pad_out, m_out);
        bus_rd(11'h400, r);
        chk("R2 direction readback", r, 8'h3C);
        bus_rd(11'h404, r);
        chk("R7 unmapped read zero", r, 8'h00);
        bus_rd(11'h400, r);
        bus_rd(11'h3FE, r);
        chk("R7 misaligned read zero", r, 8'h00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule